// File: doc/BRIEF.md
# Mode-Filtered Event Counter with Overflow Interrupt

This block is a single programmable hardware event counter for a processor core. Each cycle in which the increment strobe is high may add one to a 64-bit count. Whether it does depends on several things: whether the slot is usable, the counter's global halt bit, and a set of per-mode inhibit flags held in the counter's selector register. The current privilege level and the virtualization state pick which inhibit flag applies.

When an allowed increment finds the count at all ones, the count wraps to zero. If the selector's overflow flag is clear at that moment, the block sets it and raises a level interrupt request. The request stays high until it is acknowledged. The overflow flag stays set until software rewrites the selector, and while it is set no further interrupt is raised. A split mode lets a 32-bit host reach the count and the selector as two halves of one register each.

The count and the selector are accessed through a small register port. A write lands on the next clock edge, and the read data is combinational from the address. The slot index and the availability mask are parameters. A slot below index 3, at or beyond the slot count, or with a clear availability bit never counts.

Top module: `pmc_filtered_counter`

## Requirements
- R1: After reset the count is zero, the selector is zero and `irq_o` is low.
- R2: No increment happens while `halt_i` is high, and none ever happens when the slot is invalid: index below 3, index not below `NUM_SLOTS`, or availability bit clear. Register writes still apply in every case.
- R3: With `priv_i` = 3 (machine), the increment is suppressed when the machine-inhibit flag is set. That flag is selector bit 2*HALF_W-2.
- R4: With `virt_i` high, the increment is suppressed for `priv_i` = 1 (supervisor) when the guest-supervisor inhibit flag (bit 2*HALF_W-5) is set. It is suppressed for `priv_i` = 0 (user) when the guest-user inhibit flag (bit 2*HALF_W-6) is set.
- R5: With `virt_i` low, the increment is suppressed for `priv_i` = 1 when the supervisor inhibit flag (bit 2*HALF_W-3) is set, and for `priv_i` = 0 when the user inhibit flag (bit 2*HALF_W-4) is set. The code `priv_i` = 2 is never filtered.
- R6: An allowed increment adds one to the full 2*HALF_W-bit count. The low half carries into the high half, and the count wraps to zero only from all ones.
- R7: On a wrap, if the overflow flag (selector bit 2*HALF_W-1) is clear, it is set and the interrupt pending bit is set. If the flag is already set, the pending bit is left unchanged.
- R8: `irq_o` is the pending bit. It holds until a cycle with `irq_ack_i` high clears it. A fresh overflow in the same cycle as the acknowledge keeps it set.
- R9: The overflow flag, once set, stays set until a selector write changes it. A selector write takes priority over a same-cycle overflow setting the flag.
- R10: A count write takes priority over a same-cycle increment. The written value is stored and no increment is applied in that cycle.
- R11: Register addresses: 0 is the count, 1 is the count's upper half, 2 is the selector, 3 is the selector's upper half. With `split_mode_i` low, address 0 and 2 writes and reads cover the full width. With it high, they cover only the low half, and reads are zero-extended. Addresses 1 and 3 always write the upper half from `csr_wdata_i[HALF_W-1:0]` and read it zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Increment strobe for the selected event |
| halt_i | input | 1 | This slot's bit of the global inhibit register |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization active |
| split_mode_i | input | 1 | 1: register access in half-width pieces |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register address |
| csr_wdata_i | input | 2*HALF_W | Write data |
| csr_rdata_o | output | 2*HALF_W | Read data for `csr_addr_i` |
| irq_ack_i | input | 1 | Clears the pending interrupt |
| irq_o | output | 1 | Overflow interrupt request (level) |

## Verification
Two collisions are provoked on purpose. The first drives a count write, to the full register and to the upper half, in the same cycle as an increment strobe. The stored value must equal exactly what was written, with no increment added. The second arranges a wrap with the overflow flag clear while the pending bit is still high, and acknowledges in that same cycle. `irq_o` must stay high afterwards. Around these cases, sweeps over every filter combination and over every low-half value next to the carry and wrap boundaries compare each result against arithmetic done in the bench.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ADDR_CNT    = 2'd0,
        ADDR_CNT_HI = 2'd1,
        ADDR_SEL    = 2'd2,
        ADDR_SEL_HI = 2'd3
    } csr_addr_e;

    // Inhibit flag field: the five bits just below the overflow flag,
    // indexed here from the field's least significant bit.
    localparam int NUM_INH   = 5;
    localparam int INH_MACH  = 4;
    localparam int INH_SUP   = 3;
    localparam int INH_USR   = 2;
    localparam int INH_VSUP  = 1;
    localparam int INH_VUSR  = 0;

    // Number of low slot indices reserved for fixed counters.
    localparam int FIXED_SLOTS = 3;

endpackage

// File: rtl/pmc_mode_filter.sv
module pmc_mode_filter
    import pmc_pkg::*;
(
    input  logic [NUM_INH-1:0] inh_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    output logic               blocked_o
);

    priv_e level;

    always_comb begin
        level     = priv_e'(priv_i);
        blocked_o = 1'b0;
        unique case (level)
            PRIV_MACH:  blocked_o = inh_i[INH_MACH];
            PRIV_SUPER: blocked_o = virt_i ? inh_i[INH_VSUP] : inh_i[INH_SUP];
            PRIV_USER:  blocked_o = virt_i ? inh_i[INH_VUSR] : inh_i[INH_USR];
            default:    blocked_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmc_wrap_incr.sv
module pmc_wrap_incr #(
    parameter int HALF_W  = 32,
    parameter int NUM_SEG = 2
) (
    input  logic [NUM_SEG*HALF_W-1:0] val_i,
    output logic [NUM_SEG*HALF_W-1:0] sum_o,
    output logic                      wrap_o
);

    logic [NUM_SEG:0] carry;

    assign carry[0] = 1'b1;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        assign sum_o[s*HALF_W +: HALF_W] =
            val_i[s*HALF_W +: HALF_W] + {{(HALF_W-1){1'b0}}, carry[s]};
        assign carry[s+1] = carry[s] & (&val_i[s*HALF_W +: HALF_W]);
    end

    assign wrap_o = carry[NUM_SEG];

endmodule

// File: rtl/pmc_csr_merge.sv
module pmc_csr_merge #(
    parameter int HALF_W = 32
) (
    input  logic                  split_i,
    input  logic                  lo_hit_i,
    input  logic                  hi_hit_i,
    input  logic [2*HALF_W-1:0]   wdata_i,
    input  logic [2*HALF_W-1:0]   cur_i,
    output logic [2*HALF_W-1:0]   next_o
);

    always_comb begin
        next_o = cur_i;
        if (lo_hit_i) begin
            if (split_i) begin
                next_o[HALF_W-1:0] = wdata_i[HALF_W-1:0];
            end else begin
                next_o = wdata_i;
            end
        end else if (hi_hit_i) begin
            next_o[2*HALF_W-1:HALF_W] = wdata_i[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/pmc_filtered_counter.sv
module pmc_filtered_counter
    import pmc_pkg::*;
#(
    parameter int                  HALF_W     = 32,
    parameter int                  NUM_SLOTS  = 32,
    parameter int                  SLOT_IDX   = 3,
    parameter logic [NUM_SLOTS-1:0] AVAIL_MASK = NUM_SLOTS'(8)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  halt_i,
    input  logic [1:0]            priv_i,
    input  logic                  virt_i,
    input  logic                  split_mode_i,
    input  logic                  csr_we_i,
    input  logic [1:0]            csr_addr_i,
    input  logic [2*HALF_W-1:0]   csr_wdata_i,
    output logic [2*HALF_W-1:0]   csr_rdata_o,
    input  logic                  irq_ack_i,
    output logic                  irq_o
);

    localparam int CNT_W   = 2 * HALF_W;
    localparam int OVF_POS = CNT_W - 1;
    localparam int NUM_REG = 2;   // 0: count, 1: selector

    function automatic bit slot_usable();
        bit ok;
        ok = 1'b0;
        for (int i = FIXED_SLOTS; i < NUM_SLOTS; i++) begin
            if (i == SLOT_IDX && AVAIL_MASK[i]) ok = 1'b1;
        end
        return ok;
    endfunction

    localparam bit SLOT_OK = slot_usable();

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] sel;
        logic             pend;
    } state_t;

    state_t state_d, state_q;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   sel_q;
    logic [CNT_W-1:0]   inc_sum;
    logic               inc_wrap;
    logic               mode_blocked;
    logic               count_en;
    logic               fresh_ovf;
    logic               cnt_wr;
    logic               sel_wr;
    logic [NUM_REG-1:0] lo_hit;
    logic [NUM_REG-1:0] hi_hit;
    logic [CNT_W-1:0]   reg_cur  [NUM_REG];
    logic [CNT_W-1:0]   reg_next [NUM_REG];
    csr_addr_e          addr;

    assign cnt_q = state_q.cnt;
    assign sel_q = state_q.sel;
    assign addr  = csr_addr_e'(csr_addr_i);

    assign reg_cur[0] = cnt_q;
    assign reg_cur[1] = sel_q;

    assign lo_hit[0] = csr_we_i && (addr == ADDR_CNT);
    assign hi_hit[0] = csr_we_i && (addr == ADDR_CNT_HI);
    assign lo_hit[1] = csr_we_i && (addr == ADDR_SEL);
    assign hi_hit[1] = csr_we_i && (addr == ADDR_SEL_HI);

    assign cnt_wr = lo_hit[0] | hi_hit[0];
    assign sel_wr = lo_hit[1] | hi_hit[1];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg_port
        pmc_csr_merge #(
            .HALF_W (HALF_W)
        ) merge_i (
            .split_i  (split_mode_i),
            .lo_hit_i (lo_hit[g]),
            .hi_hit_i (hi_hit[g]),
            .wdata_i  (csr_wdata_i),
            .cur_i    (reg_cur[g]),
            .next_o   (reg_next[g])
        );
    end

    pmc_mode_filter filter_i (
        .inh_i     (sel_q[OVF_POS-1 -: NUM_INH]),
        .priv_i    (priv_i),
        .virt_i    (virt_i),
        .blocked_o (mode_blocked)
    );

    pmc_wrap_incr #(
        .HALF_W  (HALF_W),
        .NUM_SEG (2)
    ) incr_i (
        .val_i  (cnt_q),
        .sum_o  (inc_sum),
        .wrap_o (inc_wrap)
    );

    // Next-state computation
    always_comb begin
        state_d   = state_q;
        count_en  = tick_i && SLOT_OK && !halt_i && !mode_blocked && !cnt_wr;
        fresh_ovf = count_en && inc_wrap && !sel_q[OVF_POS];

        if (cnt_wr) begin
            state_d.cnt = reg_next[0];
        end else if (count_en) begin
            state_d.cnt = inc_sum;
        end

        if (sel_wr) begin
            state_d.sel = reg_next[1];
        end else if (fresh_ovf) begin
            state_d.sel[OVF_POS] = 1'b1;
        end

        if (fresh_ovf) begin
            state_d.pend = 1'b1;
        end else if (irq_ack_i) begin
            state_d.pend = 1'b0;
        end
    end

    // Read mux
    always_comb begin
        csr_rdata_o = '0;
        unique case (addr)
            ADDR_CNT: begin
                if (split_mode_i) csr_rdata_o[HALF_W-1:0] = cnt_q[HALF_W-1:0];
                else              csr_rdata_o = cnt_q;
            end
            ADDR_CNT_HI: csr_rdata_o[HALF_W-1:0] = cnt_q[CNT_W-1:HALF_W];
            ADDR_SEL: begin
                if (split_mode_i) csr_rdata_o[HALF_W-1:0] = sel_q[HALF_W-1:0];
                else              csr_rdata_o = sel_q;
            end
            ADDR_SEL_HI: csr_rdata_o[HALF_W-1:0] = sel_q[CNT_W-1:HALF_W];
            default: csr_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.pend;

endmodule

// File: rtl/pmc_filtered_counter_chk.sv
module pmc_filtered_counter_chk #(
    parameter int HALF_W  = 32,
    parameter bit SLOT_OK = 1'b1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                tick_i,
    input logic                halt_i,
    input logic [1:0]          priv_i,
    input logic                split_mode_i,
    input logic                csr_we_i,
    input logic [1:0]          csr_addr_i,
    input logic [2*HALF_W-1:0] csr_wdata_i,
    input logic                irq_ack_i,
    input logic                irq_o,
    input logic [2*HALF_W-1:0] cnt_q,
    input logic [2*HALF_W-1:0] sel_q,
    input logic                mode_blocked
);

    localparam int W = 2 * HALF_W;

    logic cnt_write;
    logic sel_write;
    assign cnt_write = csr_we_i && (csr_addr_i[1] == 1'b0);
    assign sel_write = csr_we_i && (csr_addr_i[1] == 1'b1);

    assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_addr_i == 2'd0 && !split_mode_i) |=> (cnt_q == $past(csr_wdata_i)));

    assert_halt_freezes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && !cnt_write) |=> $stable(cnt_q));

    assert_mach_inhibit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i == 2'd3 && sel_q[W-2] && !cnt_write) |=> $stable(cnt_q));

    assert_wrap_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (SLOT_OK && tick_i && !halt_i && !mode_blocked && (&cnt_q) && !cnt_write && !sel_write)
        |=> (cnt_q == '0 && sel_q[W-1]));

    assert_no_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && sel_q[W-1] && !sel_write) |=> !irq_o);

    assert_irq_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !irq_ack_i) |=> irq_o);

    assert_step_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (SLOT_OK && tick_i && !halt_i && !mode_blocked && !cnt_write && !(&cnt_q))
        |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

bind pmc_filtered_counter pmc_filtered_counter_chk #(
    .HALF_W  (HALF_W),
    .SLOT_OK (SLOT_OK)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .halt_i       (halt_i),
    .priv_i       (priv_i),
    .split_mode_i (split_mode_i),
    .csr_we_i     (csr_we_i),
    .csr_addr_i   (csr_addr_i),
    .csr_wdata_i  (csr_wdata_i),
    .irq_ack_i    (irq_ack_i),
    .irq_o        (irq_o),
    .cnt_q        (cnt_q),
    .sel_q        (sel_q),
    .mode_blocked (mode_blocked)
);

// File: tb/pmc_filtered_counter_tb_top.sv
module pmc_filtered_counter_tb_top;

    localparam int HW = 8;
    localparam int CW = 2 * HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          halt = 1'b0;
    logic [1:0]    priv = 2'd3;
    logic          virt = 1'b0;
    logic          split = 1'b0;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_addr = 2'd0;
    logic [CW-1:0] csr_wdata = '0;
    logic [CW-1:0] rdata;
    logic [CW-1:0] rdata_inv;
    logic          ack = 1'b0;
    logic          irq;
    logic          irq_inv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pmc_filtered_counter #(
        .HALF_W (HW), .NUM_SLOTS (32), .SLOT_IDX (3), .AVAIL_MASK (32'h8)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .halt_i (halt),
        .priv_i (priv), .virt_i (virt), .split_mode_i (split),
        .csr_we_i (csr_we), .csr_addr_i (csr_addr), .csr_wdata_i (csr_wdata),
        .csr_rdata_o (rdata), .irq_ack_i (ack), .irq_o (irq)
    );

    pmc_filtered_counter #(
        .HALF_W (HW), .NUM_SLOTS (32), .SLOT_IDX (4), .AVAIL_MASK (32'h8)
    ) dut_inv_i (
        .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .halt_i (halt),
        .priv_i (priv), .virt_i (virt), .split_mode_i (split),
        .csr_we_i (csr_we), .csr_addr_i (csr_addr), .csr_wdata_i (csr_wdata),
        .csr_rdata_o (rdata_inv), .irq_ack_i (ack), .irq_o (irq_inv)
    );

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CW-1:0] d);
        csr_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_tick(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    function automatic bit exp_block(input int p, input bit v, input logic [4:0] f);
        case (p)
            3: return f[4];
            1: return v ? f[1] : f[3];
            0: return v ? f[0] : f[2];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] d;
        logic [CW-1:0] d2;
        logic [CW-1:0] v;
        logic [7:0]    his [3];
        his[0] = 8'h00; his[1] = 8'h7F; his[2] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 count", d, '0);
        rd(2'd2, d); check("R1 selector", d, '0);
        check("R1 irq", {15'd0, irq}, '0);

        // R3 R4 R5 filter sweep: flags {MINH,SINH,UINH,VSINH,VUINH} at bits 14..10
        for (int p = 0; p < 4; p++) begin
            for (int vv = 0; vv < 2; vv++) begin
                for (int f = 0; f < 32; f++) begin
                    string tag;
                    bit blk;
                    priv = 2'(p); virt = vv[0];
                    wr(2'd2, CW'(f) << 10);
                    wr(2'd0, '0);
                    pulse_tick(1);
                    rd(2'd0, d);
                    blk = exp_block(p, vv[0], 5'(f));
                    tag = (p == 3) ? "R3 filter" : ((vv != 0 && p != 2) ? "R4 filter" : "R5 filter");
                    check(tag, d, blk ? 16'd0 : 16'd1);
                end
            end
        end

        priv = 2'd3; virt = 1'b0;
        wr(2'd2, '0);

        // R6 R7 wide-mode increment sweep near carry and wrap
        for (int h = 0; h < 3; h++) begin
            for (int lo = 0; lo < 256; lo++) begin
                v = {his[h], 8'(lo)};
                wr(2'd0, v);
                pulse_tick(1);
                rd(2'd0, d);
                check("R6 wide increment", d, v + 16'd1);
                if (v == 16'hFFFF) begin
                    check("R7 wrap irq", {15'd0, irq}, 16'd1);
                    rd(2'd2, d);
                    check("R7 flag set", d, 16'h8000);
                    wr(2'd2, '0);
                    pulse_ack();
                end
            end
        end

        // R11 R6 split-mode sweep: halves written and read separately
        split = 1'b1;
        for (int h = 0; h < 3; h++) begin
            for (int lo = 0; lo < 256; lo++) begin
                v = {his[h], 8'(lo)};
                wr(2'd0, {8'h00, v[7:0]});
                wr(2'd1, {8'h00, v[15:8]});
                pulse_tick(1);
                rd(2'd0, d);
                rd(2'd1, d2);
                check("R11 split increment", {d2[7:0], d[7:0]}, v + 16'd1);
                check("R11 split zero-extend", {d2[15:8], d[15:8]}, '0);
                if (v == 16'hFFFF) begin
                    check("R7 split wrap irq", {15'd0, irq}, 16'd1);
                    rd(2'd3, d);
                    check("R7 split flag", d, 16'h0080);
                    wr(2'd3, '0);
                    pulse_ack();
                end
            end
        end
        split = 1'b0;

        // R7 no new interrupt when the flag is already set
        wr(2'd2, 16'h8000);
        wr(2'd0, 16'hFFFF);
        pulse_tick(1);
        rd(2'd0, d); check("R7 wrap with flag set", d, '0);
        check("R7 no re-raise", {15'd0, irq}, '0);

        // R9 sticky flag
        wr(2'd2, '0);
        wr(2'd0, 16'hFFFF);
        pulse_tick(4);
        rd(2'd2, d); check("R9 flag sticky", d, 16'h8000);
        pulse_ack();
        check("R8 ack clears", {15'd0, irq}, '0);
        wr(2'd2, '0);
        rd(2'd2, d); check("R9 cleared by write", d, '0);

        // R8 level hold and overflow colliding with acknowledge
        wr(2'd0, 16'hFFFF);
        pulse_tick(1);
        repeat (5) @(negedge clk);
        check("R8 hold", {15'd0, irq}, 16'd1);
        wr(2'd2, '0);
        check("R8 hold after selector write", {15'd0, irq}, 16'd1);
        wr(2'd0, 16'hFFFF);
        @(negedge clk);
        tick = 1'b1; ack = 1'b1;
        @(negedge clk);
        tick = 1'b0; ack = 1'b0;
        check("R8 overflow beats ack", {15'd0, irq}, 16'd1);
        pulse_ack();
        check("R8 ack", {15'd0, irq}, '0);
        wr(2'd2, '0);

        // R10 count write in the same cycle as an increment
        wr(2'd0, 16'h0010);
        @(negedge clk);
        tick = 1'b1; csr_we = 1'b1; csr_addr = 2'd0; csr_wdata = 16'h1234;
        @(negedge clk);
        tick = 1'b0; csr_we = 1'b0;
        rd(2'd0, d); check("R10 full write wins", d, 16'h1234);
        @(negedge clk);
        tick = 1'b1; csr_we = 1'b1; csr_addr = 2'd1; csr_wdata = 16'h0056;
        @(negedge clk);
        tick = 1'b0; csr_we = 1'b0;
        rd(2'd0, d); check("R10 upper write wins", d, 16'h5634);

        // R2 halt and invalid slot
        wr(2'd0, 16'd5);
        halt = 1'b1;
        pulse_tick(4);
        rd(2'd0, d); check("R2 halted", d, 16'd5);
        halt = 1'b0;
        pulse_tick(10);
        rd(2'd0, d); check("R2 resumes", d, 16'd15);
        check("R2 invalid slot frozen", rdata_inv, 16'd5);

        // R11 split access to count and selector
        split = 1'b1;
        wr(2'd0, 16'hABCD);
        rd(2'd0, d); check("R11 split low write", d, 16'h00CD);
        wr(2'd1, 16'hFF12);
        rd(2'd1, d); check("R11 upper write", d, 16'h0012);
        split = 1'b0;
        rd(2'd0, d); check("R11 wide read", d, 16'h12CD);
        wr(2'd1, 16'h0034);
        rd(2'd0, d); check("R11 wide upper write", d, 16'h34CD);
        split = 1'b1;
        wr(2'd3, 16'h0040);
        priv = 2'd3;
        pulse_tick(3);
        rd(2'd0, d); check("R3 split machine inhibit", d, 16'h00CD);
        rd(2'd2, d); check("R11 selector low half", d, '0);
        rd(2'd3, d); check("R11 selector upper half", d, 16'h0040);
        split = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule